// File: doc/BRIEF.md
# Shadow-Diff Character Screen Updater

This block keeps the character memory of an external on-screen display in step with a local frame buffer, while sending as little as possible. A shadow copy holds what the display is believed to show. Each pass walks the frame buffer from a persistent scan position and compares every character with the shadow. Only the characters that differ become register-write pairs in a byte stream. Each pair is a register address byte followed by a data byte. The shadow is updated as characters are sent.

Within a pass, a run of changed characters is sent either as one addressed write or as an auto-increment burst. A one-character lookahead at the start of each run picks the form. A pass ends at whichever comes first: half of the screen, a byte budget, or the end of the screen. The caller issues passes until the more-pending flag drops. A force-redraw request zeroes the shadow, so the next full sweep resends every character. The stream goes through a small pair FIFO to a valid/ready byte output. Serial transmission is left to the consumer.

Top module: `scr_diff_updater`

## Requirements
- R1: After reset, `busy_o`, `more_o` and `out_valid_o` are low, and the shadow holds 0x00 everywhere.
- R2: A changed character whose next position is unchanged is sent as four pairs: (0x04, base with bit 0 clear), (0x05, position bits above 7), (0x06, position bits 7:0), (0x07, character). Each pair is sent as the register byte first, then the data byte.
- R3: A run of two or more changed characters opens with (0x04, base with bit 0 set) and the address pairs. Each character of the run is then sent as (0x07, character). The first unchanged position afterwards emits (0x07, 0xFF). A pass in which auto-increment was selected ends with (0x04, base with bit 0 clear).
- R4: A frame-buffer value of 0xFF is sent as 0x20 and is stored in the shadow as 0x20. It is therefore not sent again on later passes.
- R5: Characters equal to the shadow emit nothing. Once a sweep has completed, a further sweep over an unchanged frame buffer emits no bytes.
- R6: A pass examines at most half the screen's positions. The scan position persists across passes and wraps to 0 after the last position. `more_o` is high exactly while the position is non-zero.
- R7: Before each position, the pass stops if the bytes it has emitted are not below the budget minus 12. The budget is 250 bytes, or 20 bytes with `slow_i` set. With every character changed in fast mode, the first pass therefore sends 116 characters in 242 bytes. In slow mode it sends 1 character in 12 bytes.
- R8: A pass that stops inside an auto-increment run emits (0x07, 0xFF) and then (0x04, base with bit 0 clear).
- R9: Lines are 30 characters long. `pal_i` selects 16 rows (480 positions); otherwise 13 rows (390 positions) are used. The selection is sampled at the start of each pass, and positions at or beyond the screen size are never sent.
- R10: `force_redraw_i` zeroes the shadow. It takes effect at once when the scanner is idle, including in the same cycle as a start. If it arrives during a pass, it is held and applied when that pass ends.
- R11: When `out_ready_i` is low, `out_valid_o` and `out_data_o` hold their values. No byte is lost or duplicated.
- R12: The lookahead at the last screen position always counts as unchanged, so that position is sent without auto-increment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin one pass; taken only when `busy_o` is low |
| force_redraw_i | input | 1 | Request a shadow clear (full redraw) |
| pal_i | input | 1 | 1: 16-row screen, 0: 13-row screen |
| slow_i | input | 1 | Select the small byte budget |
| mode_base_i | input | 8 | Base value of the mode register (bit 0 is replaced) |
| fb_cur_addr_o | output | 9 | Frame-buffer address of the current position |
| fb_cur_data_i | input | 8 | Frame-buffer data at `fb_cur_addr_o` (combinational) |
| fb_nxt_addr_o | output | 9 | Frame-buffer address of the lookahead position |
| fb_nxt_data_i | input | 8 | Frame-buffer data at `fb_nxt_addr_o` (combinational) |
| out_data_o | output | 8 | Stream byte |
| out_valid_o | output | 1 | Stream byte valid |
| out_ready_i | input | 1 | Consumer accepts the byte |
| busy_o | output | 1 | Pass in progress or bytes still queued |
| more_o | output | 1 | Scan position is non-zero; more passes are needed |

## Verification
The shadow clear can coincide with a pass, in two ways. A force request can arrive in the very cycle a pass is started. It can also arrive while the scanner is busy writing shadow entries. The bench provokes the first with `start_i` and `force_redraw_i` raised together, and expects the opening pass to treat every position as changed. It provokes the second by pulsing the request twenty cycles into a pass over a synchronised screen. Here it expects that pass to emit nothing, the rest of the sweep to resend exactly the 240 positions it still covers, and the following sweep to resend the other 240. A model of the display, decoded from the stream under a stalling ready pattern, must match the frame buffer after each sweep.

// File: rtl/sdu_pkg.sv
package sdu_pkg;
  localparam logic [7:0] REG_MODE = 8'h04;
  localparam logic [7:0] REG_AH   = 8'h05;
  localparam logic [7:0] REG_AL   = 8'h06;
  localparam logic [7:0] REG_DATA = 8'h07;
  localparam logic [7:0] CH_TERM  = 8'hFF;
  localparam logic [7:0] CH_BLANK = 8'h20;
  localparam logic [7:0] AUTO_BIT = 8'h01;

  typedef struct packed {
    logic [7:0] reg_a;
    logic [7:0] val;
  } sdu_pair_t;

  typedef enum logic [3:0] {
    S_IDLE, S_CHECK, S_MODE, S_AH, S_AL, S_DATA, S_CLOSE, S_FIN, S_FCLOSE, S_FREST
  } sdu_state_e;

  function automatic logic [7:0] sdu_map(input logic [7:0] c);
    return (c == CH_TERM) ? CH_BLANK : c;
  endfunction
endpackage

// File: rtl/sdu_shadow.sv
module sdu_shadow #(
  parameter int DEPTH = 480,
  parameter int AW    = 9
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [7:0]    wdata_i,
  input  logic [AW-1:0] raddr_a_i,
  output logic [7:0]    rdata_a_o,
  input  logic [AW-1:0] raddr_b_i,
  output logic [7:0]    rdata_b_o
);
  logic [7:0] mem_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (clr_i) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (we_i && (int'(waddr_i) < DEPTH)) begin
      mem_q[waddr_i] <= wdata_i;
    end
  end

  assign rdata_a_o = (int'(raddr_a_i) < DEPTH) ? mem_q[raddr_a_i] : '0;
  assign rdata_b_o = (int'(raddr_b_i) < DEPTH) ? mem_q[raddr_b_i] : '0;

  a_r10_no_write_on_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |-> !we_i);
  a_r10_clear_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (rdata_a_o == 8'h00) && (rdata_b_o == 8'h00));
endmodule

// File: rtl/sdu_fifo.sv
module sdu_fifo #(
  parameter int W     = 16,
  parameter int DEPTH = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic [W-1:0] din_i,
  output logic         full_o,
  input  logic         pop_i,
  output logic [W-1:0] dout_o,
  output logic         empty_o
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  buf_q [DEPTH];
  logic [AW-1:0] wr_q, rd_q;
  logic [CW-1:0] cnt_q;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (int'(p) == DEPTH - 1) ? '0 : p + AW'(1);
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
      for (int i = 0; i < DEPTH; i++) buf_q[i] <= '0;
    end else begin
      if (push_i) begin
        buf_q[wr_q] <= din_i;
        wr_q        <= bump(wr_q);
      end
      if (pop_i) rd_q <= bump(rd_q);
      if (push_i && !pop_i)      cnt_q <= cnt_q + CW'(1);
      else if (pop_i && !push_i) cnt_q <= cnt_q - CW'(1);
    end
  end

  assign full_o  = (int'(cnt_q) == DEPTH);
  assign empty_o = (cnt_q == '0);
  assign dout_o  = buf_q[rd_q];

  a_r11_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> (!full_o || pop_i));
  a_r11_no_underflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> !empty_o);
endmodule

// File: rtl/sdu_scan.sv
module sdu_scan
  import sdu_pkg::*;
#(
  parameter int POS_W       = 9,
  parameter int CNT_W       = 9,
  parameter int PAL_CHARS   = 480,
  parameter int NTSC_CHARS  = 390,
  parameter int BUDGET_FAST = 250,
  parameter int BUDGET_SLOW = 20,
  parameter int RESERVE     = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             force_i,
  input  logic             pal_i,
  input  logic             slow_i,
  input  logic [7:0]       base_i,
  input  logic [7:0]       cur_data_i,
  input  logic [7:0]       nxt_data_i,
  input  logic [7:0]       sh_cur_i,
  input  logic [7:0]       sh_nxt_i,
  input  logic             full_i,
  output logic [POS_W-1:0] pos_o,
  output logic [POS_W-1:0] nxt_pos_o,
  output logic             push_o,
  output sdu_pair_t        pair_o,
  output logic             sh_we_o,
  output logic [7:0]       sh_wdata_o,
  output logic             clr_o,
  output logic             busy_o,
  output logic             more_o
);
  localparam logic [POS_W-1:0] PAL_SZ   = POS_W'(PAL_CHARS);
  localparam logic [POS_W-1:0] NTSC_SZ  = POS_W'(NTSC_CHARS);
  localparam logic [CNT_W-1:0] LIM_FAST = CNT_W'(BUDGET_FAST - RESERVE);
  localparam logic [CNT_W-1:0] LIM_SLOW = CNT_W'(BUDGET_SLOW - RESERVE);

  sdu_state_e       state_q;
  logic [POS_W-1:0] pos_q, size_q;
  logic [POS_W:0]   lim_q;
  logic [CNT_W-1:0] cnt_q, cnt_lim_q;
  logic             set_addr_q, auto_q, clr_pend_q;

  logic [7:0]       cur_ch, nxt_ch, mode_clr;
  logic [POS_W:0]   pos_inc;
  logic             at_end, cur_diff, nxt_diff, room;
  logic [POS_W-1:0] adv_pos, new_size, start_pos;
  sdu_state_e       adv_state;

  always_comb begin
    cur_ch    = sdu_map(cur_data_i);
    nxt_ch    = sdu_map(nxt_data_i);
    mode_clr  = base_i & ~AUTO_BIT;
    pos_inc   = {1'b0, pos_q} + (POS_W+1)'(1);
    at_end    = pos_inc >= {1'b0, size_q};
    cur_diff  = cur_ch != sh_cur_i;
    nxt_diff  = !at_end && (nxt_ch != sh_nxt_i);   // R12: no lookahead past the end
    room      = (cnt_q < cnt_lim_q) && ({1'b0, pos_q} < lim_q);
    adv_pos   = at_end ? '0 : pos_inc[POS_W-1:0];
    adv_state = at_end ? S_FIN : S_CHECK;
    new_size  = pal_i ? PAL_SZ : NTSC_SZ;
    start_pos = (pos_q >= new_size) ? '0 : pos_q;
  end

  always_comb begin
    push_o     = 1'b0;
    pair_o     = '{reg_a: REG_DATA, val: CH_TERM};
    sh_we_o    = 1'b0;
    sh_wdata_o = cur_ch;
    unique case (state_q)
      S_MODE:   begin push_o = !full_i; pair_o = '{REG_MODE, mode_clr | {7'b0, nxt_diff}}; end
      S_AH:     begin push_o = !full_i; pair_o = '{REG_AH, 8'(pos_q >> 8)}; end
      S_AL:     begin push_o = !full_i; pair_o = '{REG_AL, 8'(pos_q)}; end
      S_DATA:   begin push_o = !full_i; pair_o = '{REG_DATA, cur_ch}; sh_we_o = !full_i; end
      S_CLOSE,
      S_FCLOSE: push_o = !full_i;
      S_FREST:  begin push_o = !full_i; pair_o = '{REG_MODE, mode_clr}; end
      default:  ;
    endcase
  end

  assign clr_o     = (state_q == S_IDLE) && (force_i || clr_pend_q);
  assign busy_o    = state_q != S_IDLE;
  assign more_o    = pos_q != '0;
  assign pos_o     = pos_q;
  assign nxt_pos_o = pos_inc[POS_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= S_IDLE;
      pos_q      <= '0;
      lim_q      <= '0;
      size_q     <= PAL_SZ;
      cnt_q      <= '0;
      cnt_lim_q  <= LIM_FAST;
      set_addr_q <= 1'b1;
      auto_q     <= 1'b0;
      clr_pend_q <= 1'b0;
    end else begin
      if (clr_o) clr_pend_q <= 1'b0;
      else if (force_i && busy_o) clr_pend_q <= 1'b1;
      if (push_o) cnt_q <= cnt_q + CNT_W'(2);
      unique case (state_q)
        S_IDLE: if (start_i) begin
          size_q     <= new_size;
          cnt_lim_q  <= slow_i ? LIM_SLOW : LIM_FAST;
          pos_q      <= start_pos;
          lim_q      <= {1'b0, start_pos} + {1'b0, new_size >> 1};
          cnt_q      <= '0;
          set_addr_q <= 1'b1;
          auto_q     <= 1'b0;
          state_q    <= S_CHECK;
        end
        S_CHECK: begin
          if (!room) state_q <= S_FIN;
          else if (cur_diff) state_q <= (set_addr_q || !auto_q) ? S_MODE : S_DATA;
          else begin
            set_addr_q <= 1'b1;
            if (!set_addr_q && auto_q) state_q <= S_CLOSE;
            else begin
              pos_q   <= adv_pos;
              state_q <= adv_state;
            end
          end
        end
        S_MODE: if (push_o) begin auto_q <= nxt_diff; state_q <= S_AH; end
        S_AH:   if (push_o) state_q <= S_AL;
        S_AL:   if (push_o) begin set_addr_q <= 1'b0; state_q <= S_DATA; end
        S_DATA, S_CLOSE: if (push_o) begin pos_q <= adv_pos; state_q <= adv_state; end
        S_FIN: begin
          if (auto_q && !set_addr_q) state_q <= S_FCLOSE;
          else if (auto_q)           state_q <= S_FREST;
          else                       state_q <= S_IDLE;
        end
        S_FCLOSE: if (push_o) state_q <= S_FREST;
        S_FREST:  if (push_o) state_q <= S_IDLE;
        default:  state_q <= S_IDLE;
      endcase
    end
  end

  a_r7_budget: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> ({1'b0, cnt_q} <= {1'b0, cnt_lim_q} + (CNT_W+1)'(RESERVE)));
  a_r6_pos_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> (pos_q < size_q));
  a_r6_wrap_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $fell(more_o)) |-> (state_q == S_FIN));
endmodule

// File: rtl/scr_diff_updater.sv
module scr_diff_updater
  import sdu_pkg::*;
#(
  parameter int LINE_CHARS  = 30,
  parameter int PAL_ROWS    = 16,
  parameter int NTSC_ROWS   = 13,
  parameter int BUDGET_FAST = 250,
  parameter int BUDGET_SLOW = 20,
  parameter int RESERVE     = 12,
  parameter int FIFO_DEPTH  = 4,
  localparam int PAL_CHARS  = LINE_CHARS * PAL_ROWS,
  localparam int NTSC_CHARS = LINE_CHARS * NTSC_ROWS,
  localparam int POS_W      = $clog2(PAL_CHARS + 1),
  localparam int CNT_W      = $clog2(BUDGET_FAST + RESERVE + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             force_redraw_i,
  input  logic             pal_i,
  input  logic             slow_i,
  input  logic [7:0]       mode_base_i,
  output logic [POS_W-1:0] fb_cur_addr_o,
  input  logic [7:0]       fb_cur_data_i,
  output logic [POS_W-1:0] fb_nxt_addr_o,
  input  logic [7:0]       fb_nxt_data_i,
  output logic [7:0]       out_data_o,
  output logic             out_valid_o,
  input  logic             out_ready_i,
  output logic             busy_o,
  output logic             more_o
);
  logic       scan_busy, push, full, empty, pop, sh_we, clr, phase_q;
  logic [7:0] sh_cur, sh_nxt, sh_wdata;
  sdu_pair_t  pair_in, pair_out;

  sdu_scan #(
    .POS_W(POS_W), .CNT_W(CNT_W), .PAL_CHARS(PAL_CHARS), .NTSC_CHARS(NTSC_CHARS),
    .BUDGET_FAST(BUDGET_FAST), .BUDGET_SLOW(BUDGET_SLOW), .RESERVE(RESERVE)
  ) u_scan (
    .clk_i, .rst_ni,
    .start_i    (start_i && !busy_o),
    .force_i    (force_redraw_i),
    .pal_i, .slow_i,
    .base_i     (mode_base_i),
    .cur_data_i (fb_cur_data_i),
    .nxt_data_i (fb_nxt_data_i),
    .sh_cur_i   (sh_cur),
    .sh_nxt_i   (sh_nxt),
    .full_i     (full),
    .pos_o      (fb_cur_addr_o),
    .nxt_pos_o  (fb_nxt_addr_o),
    .push_o     (push),
    .pair_o     (pair_in),
    .sh_we_o    (sh_we),
    .sh_wdata_o (sh_wdata),
    .clr_o      (clr),
    .busy_o     (scan_busy),
    .more_o     (more_o)
  );

  sdu_shadow #(.DEPTH(PAL_CHARS), .AW(POS_W)) u_shadow (
    .clk_i, .rst_ni,
    .clr_i     (clr),
    .we_i      (sh_we),
    .waddr_i   (fb_cur_addr_o),
    .wdata_i   (sh_wdata),
    .raddr_a_i (fb_cur_addr_o),
    .rdata_a_o (sh_cur),
    .raddr_b_i (fb_nxt_addr_o),
    .rdata_b_o (sh_nxt)
  );

  sdu_fifo #(.W($bits(sdu_pair_t)), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk_i, .rst_ni,
    .push_i  (push),
    .din_i   (pair_in),
    .full_o  (full),
    .pop_i   (pop),
    .dout_o  (pair_out),
    .empty_o (empty)
  );

  // register byte first, then data byte
  assign out_valid_o = !empty;
  assign out_data_o  = phase_q ? pair_out.val : pair_out.reg_a;
  assign pop         = out_valid_o && out_ready_i && phase_q;
  assign busy_o      = scan_busy || !empty;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                         phase_q <= 1'b0;
    else if (out_valid_o && out_ready_i) phase_q <= !phase_q;
  end

  a_r11_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_ready_i) |=> (out_valid_o && $stable(out_data_o)));
endmodule

// File: tb/scr_diff_updater_tb.sv
module scr_diff_updater_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 0, force_r = 0, pal = 1, slow = 0, ready = 1, stall_en = 1;
  logic [7:0] base = 8'h00;
  logic [8:0] fb_cur_addr, fb_nxt_addr;
  logic [7:0] out_data;
  logic out_valid, busy, more;
  logic [7:0] fb [0:511];
  logic [7:0] disp [0:511];

  int total = 0, bad = 0, cyc = 0;
  int np = 0, nbytes = 0, pchars = 0;
  logic [15:0] pairs [0:299];
  logic [15:0] exp_p [0:15];
  logic ph = 0, dauto = 0;
  logic [7:0] rbyte;
  logic [15:0] daddr = 0;

  always #2 clk = ~clk;

  scr_diff_updater u_dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .force_redraw_i(force_r),
    .pal_i(pal), .slow_i(slow), .mode_base_i(base),
    .fb_cur_addr_o(fb_cur_addr), .fb_cur_data_i(fb[fb_cur_addr]),
    .fb_nxt_addr_o(fb_nxt_addr), .fb_nxt_data_i(fb[fb_nxt_addr]),
    .out_data_o(out_data), .out_valid_o(out_valid), .out_ready_i(ready),
    .busy_o(busy), .more_o(more)
  );

  function automatic logic [7:0] mapc(input logic [7:0] c);
    return (c == 8'hFF) ? 8'h20 : c;
  endfunction

  always @(posedge clk) begin
    cyc <= cyc + 1;
    #1 ready = !(stall_en && ((cyc % 5) == 2 || (cyc % 7) == 3));
  end

  // stream monitor and display model
  always @(negedge clk) begin
    if (rst_n && out_valid && ready) begin
      nbytes++;
      if (!ph) rbyte = out_data;
      else begin
        if (np < 300) pairs[np] = {rbyte, out_data};
        np++;
        case (rbyte)
          8'h04: dauto = out_data[0];
          8'h05: daddr[15:8] = out_data;
          8'h06: daddr[7:0] = out_data;
          8'h07: if (!(dauto && out_data == 8'hFF)) begin
                   if (daddr < 512) disp[daddr[8:0]] = out_data;
                   pchars++;
                   if (dauto) daddr++;
                 end
          default: ;
        endcase
      end
      ph = !ph;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_pass(input int force_at);
    np = 0; nbytes = 0; pchars = 0;
    @(posedge clk); #1 start = 1; if (force_at == 0) force_r = 1;
    @(posedge clk); #1 start = 0; force_r = 0;
    if (force_at > 0) begin
      repeat (force_at - 1) @(posedge clk);
      #1 force_r = 1;
      @(posedge clk); #1 force_r = 0;
    end
    do @(negedge clk); while (busy);
  endtask

  task automatic sweep(output int chars);
    int n = 0;
    chars = 0;
    do begin
      do_pass(-1);
      chars += pchars;
      n++;
    end while (more && n < 1000);
  endtask

  task automatic cmp_pairs(input int n, input string tag);
    chk(np == n, {tag, " pair count"}, np, n);
    for (int i = 0; i < n && i < np; i++)
      chk(pairs[i] == exp_p[i], {tag, " pair"}, pairs[i], exp_p[i]);
  endtask

  task automatic chk_disp(input int size, input string tag);
    int errs = 0;
    for (int i = 0; i < size; i++) if (disp[i] !== mapc(fb[i])) errs++;
    chk(errs == 0, tag, errs, 0);
  endtask

  task automatic t_reset;
    chk(!busy && !more && !out_valid, "R1 reset outputs", {busy, more, out_valid}, 0);
  endtask

  task automatic t_full_sweep;
    int c;
    do_pass(-1);
    chk(nbytes == 242, "R7 fast budget bytes", nbytes, 242);
    chk(pchars == 116, "R7 fast budget chars", pchars, 116);
    chk(more == 1'b1, "R6 more after first pass", more, 1);
    sweep(c);
    chk(c + 116 == 480, "R9 pal screen chars", c + 116, 480);
    chk(more == 1'b0, "R6 wrap to zero", more, 0);
    chk_disp(480, "R11 display after sweep");
  endtask

  task automatic t_idle;
    do_pass(-1);
    chk(nbytes == 0 && more, "R5 R6 idle half pass", nbytes, 0);
    do_pass(-1);
    chk(nbytes == 0 && !more, "R5 R6 idle second half", nbytes, 0);
  endtask

  task automatic t_single;
    base = 8'h08; fb[37] = 8'h41;
    do_pass(-1);
    exp_p[0] = 16'h0408; exp_p[1] = 16'h0500; exp_p[2] = 16'h0625; exp_p[3] = 16'h0741;
    cmp_pairs(4, "R2 single");
    do_pass(-1);
    base = 8'h00;
  endtask

  task automatic t_run;
    fb[300] = 8'h50; fb[301] = 8'h51; fb[302] = 8'h52;
    do_pass(-1);
    chk(nbytes == 0, "R3 first half untouched", nbytes, 0);
    do_pass(-1);
    exp_p[0] = 16'h0401; exp_p[1] = 16'h0501; exp_p[2] = 16'h062C; exp_p[3] = 16'h0750;
    exp_p[4] = 16'h0751; exp_p[5] = 16'h0752; exp_p[6] = 16'h07FF; exp_p[7] = 16'h0400;
    cmp_pairs(8, "R3 run");
  endtask

  task automatic t_ffmap;
    int c;
    fb[5] = 8'h33;
    sweep(c);
    fb[5] = 8'hFF;
    do_pass(-1);
    exp_p[0] = 16'h0400; exp_p[1] = 16'h0500; exp_p[2] = 16'h0605; exp_p[3] = 16'h0720;
    cmp_pairs(4, "R4 ff mapped");
    do_pass(-1);
    do_pass(-1);
    chk(nbytes == 0, "R4 no resend", nbytes, 0);
    do_pass(-1);
  endtask

  task automatic t_end_run;
    fb[238] = 8'h61; fb[239] = 8'h62; fb[240] = 8'h63;
    do_pass(-1);
    exp_p[0] = 16'h0401; exp_p[1] = 16'h0500; exp_p[2] = 16'h06EE; exp_p[3] = 16'h0761;
    exp_p[4] = 16'h0762; exp_p[5] = 16'h07FF; exp_p[6] = 16'h0400;
    cmp_pairs(7, "R8 run cut at half");
    do_pass(-1);
    exp_p[0] = 16'h0400; exp_p[1] = 16'h0500; exp_p[2] = 16'h06F0; exp_p[3] = 16'h0763;
    cmp_pairs(4, "R6 resume position");
  endtask

  task automatic t_last;
    fb[479] = 8'h71; fb[0] = 8'h72;
    do_pass(-1);
    exp_p[0] = 16'h0400; exp_p[1] = 16'h0500; exp_p[2] = 16'h0600; exp_p[3] = 16'h0772;
    cmp_pairs(4, "R12 first position");
    do_pass(-1);
    exp_p[0] = 16'h0400; exp_p[1] = 16'h0501; exp_p[2] = 16'h06DF; exp_p[3] = 16'h0771;
    cmp_pairs(4, "R12 last position");
    chk(!more, "R6 wrap after last", more, 0);
  endtask

  task automatic t_ntsc;
    pal = 0; fb[389] = 8'h44; fb[400] = 8'h45;
    do_pass(-1);
    chk(nbytes == 0 && more, "R9 ntsc first half", nbytes, 0);
    do_pass(-1);
    exp_p[0] = 16'h0400; exp_p[1] = 16'h0501; exp_p[2] = 16'h0685; exp_p[3] = 16'h0744;
    cmp_pairs(4, "R9 ntsc end");
    chk(!more, "R9 ntsc wrap", more, 0);
    pal = 1; fb[400] = 8'h20;
  endtask

  task automatic t_force_defer;
    int c;
    do_pass(20);
    chk(nbytes == 0, "R10 deferred clear", nbytes, 0);
    sweep(c);
    chk(c == 240, "R10 rest of sweep", c, 240);
    sweep(c);
    chk(c == 240, "R10 next sweep", c, 240);
    chk_disp(480, "R10 display");
  endtask

  task automatic t_slow_force;
    int c;
    slow = 1;
    do_pass(0);
    chk(nbytes == 12, "R7 slow budget bytes", nbytes, 12);
    chk(pchars == 1, "R10 start with clear", pchars, 1);
    slow = 0;
    sweep(c);
    chk(c == 479, "R10 full redraw", c, 479);
    chk_disp(480, "R11 display final");
  endtask

  initial begin
    #(4 * 190000);
    bad++; total++;
    $display("FAIL watchdog actual=%0d expected=0", cyc);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 512; i++) begin fb[i] = 8'h20; disp[i] = 8'h00; end
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    t_reset();
    t_full_sweep();
    t_idle();
    t_single();
    t_run();
    t_ffmap();
    t_end_run();
    t_last();
    t_ntsc();
    t_force_defer();
    t_slow_force();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule